// File: doc/BRIEF.md
# Serial Output Freeze Controller

This block sits in front of a set of clock output drivers and lets a host stop or restart individual clocks through a two-wire serial path. The host shifts in a framed word on a serial data line. A free-running serial clock samples that line on every rising edge. The word holds one enable bit per gateable output. A cleared bit parks its output at logic 0. A set bit lets the clock through again. Neither change may shorten a high pulse.

There are fourteen clock lanes. Lanes 0 to 11 can be frozen, and lanes 12 and 13 cannot. The two fixed lanes carry the clocks that must never stop, such as the loop feedback clock, so a corrupted serial word can never stall the system. Each enable bit is carried into its own output clock domain through a synchronizer. The enable then changes only on a falling edge of that lane's clock.

A low level on the master reset disables every output, and clears the serial receiver to its idle state. Once reset is released, every lane runs.

Top module: `clk_freeze_ctrl`

## Requirements
- R1: A frame is a single 0 start bit followed by 12 data bits D0..D11, in that order, one per serial clock period. Every bit is sampled on the rising edge of `sclk`.
- R2: While `sdata` stays high between frames, no frame starts and the enables keep their values.
- R3: All 12 enables change together, on the `sclk` rising edge that samples D11. Outputs keep their previous state until that edge.
- R4: Data bit Dk controls output lane k, for k = 0..11. The lanes are grouped as follows: 0..3 is bank A, 4..7 is bank B, 8..10 is bank C outputs 1..3, and 11 is the sync output.
- R5: A data bit of 0 freezes its lane, so `clk_out[k]` stays at 0. A data bit of 1 enables the lane, so `clk_out[k]` follows `clk_in[k]`.
- R6: Lanes 12 and 13 are never frozen. Outside reset they always follow their input clocks, whatever value was loaded.
- R7: While `rst_n` is low, every output is 0. After release, all 12 enables are 1 and every lane runs.
- R8: Gating never produces a partial pulse. A lane's output is either high for the whole high phase of its input clock or low for all of it, and it is low whenever its input clock is low.
- R9: A new start bit may come directly after D11 of the previous frame. The later frame is then the one in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Free-running serial clock; data sampled on its rising edge |
| rst_n | input | 1 | Master reset, active low, asynchronous assertion |
| sdata | input | 1 | Serial frame input, idles high |
| clk_in | input | 14 | Ungated clocks; lanes 0..11 gateable, 12..13 fixed |
| clk_out | output | 14 | Gated clocks, one per input lane |

## Verification
The receiver assertions assume that `sdata` holds steady around each rising edge of `sclk`. The bench meets this by changing the line only on falling edges. The gating logic assumes that each input clock keeps toggling, because an enable cannot move until that lane produces falling edges. All fourteen bench clocks therefore run continuously, at distinct periods. The bench compares outputs against its model only after the slowest lane has had several falling edges to take up a new enable. The partial-pulse monitor ignores any high phase during which reset was asserted.

// File: rtl/clk_freeze_pkg.sv
`timescale 1ns/100ps
package clk_freeze_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;

endpackage

// File: rtl/frz_rst_sync.sv
`timescale 1ns/100ps
module frz_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];

endmodule

// File: rtl/frz_frame_rx.sv
`timescale 1ns/100ps
module frz_frame_rx
  import clk_freeze_pkg::*;
#(
  parameter int unsigned NBITS = 12
) (
  input  logic             sclk,
  input  logic             srst_n,
  input  logic             sdata,
  output logic [NBITS-1:0] en_bits
);

  localparam int unsigned CW = $clog2(NBITS);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  rx_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [NBITS-1:0] shf_q, shf_d;
  logic [NBITS-1:0] en_q, en_d;
  logic             shift_en;
  logic             load_en;

  assign shift_en = (state_q == RX_DATA);
  assign load_en  = shift_en && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shf_d   = shf_q;
    en_d    = en_q;
    case (state_q)
      RX_IDLE: begin
        if (!sdata) begin
          state_d = RX_DATA;
          cnt_d   = '0;
        end
      end
      RX_DATA: begin
        shf_d[cnt_q] = sdata;
        if (load_en) begin
          en_d    = shf_d;
          state_d = RX_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shf_q   <= '0;
      en_q    <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (shift_en) shf_q <= shf_d;
      if (load_en)  en_q  <= en_d;
    end
  end

  assign en_bits = en_q;

  // R3
  commit_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    !$stable(en_q) |-> $past(state_q == RX_DATA && cnt_q == LAST));

  // R2
  idle_hold_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    (state_q == RX_IDLE && sdata) |=> (state_q == RX_IDLE && $stable(en_q)));

  // R1
  start_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    (state_q == RX_IDLE && !sdata) |=> (state_q == RX_DATA && cnt_q == '0));

  // R9
  cnt_range_chk: assert property (@(posedge sclk) disable iff (!srst_n)
    (state_q == RX_DATA && cnt_q == LAST) |=> (state_q == RX_IDLE));

endmodule

// File: rtl/frz_gate_cell.sv
`timescale 1ns/100ps
module frz_gate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en_async,
  output logic clk_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   en_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], en_async};
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= sync_q[SYNC_STAGES-1];
  end

  assign clk_out = clk_in & en_q;

endmodule

// File: rtl/clk_freeze_ctrl.sv
`timescale 1ns/100ps
module clk_freeze_ctrl #(
  parameter int unsigned NUM_GATED   = 12,
  parameter int unsigned NUM_FIXED   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_LANES  = NUM_GATED + NUM_FIXED
) (
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 sdata,
  input  logic [NUM_LANES-1:0] clk_in,
  output logic [NUM_LANES-1:0] clk_out
);

  logic                 srst_n;
  logic [NUM_GATED-1:0] en_bits;

  frz_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (sclk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  frz_frame_rx #(.NBITS(NUM_GATED)) u_rx (
    .sclk    (sclk),
    .srst_n  (srst_n),
    .sdata   (sdata),
    .en_bits (en_bits)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic lane_en;
    if (i < NUM_GATED) begin : g_gated
      assign lane_en = en_bits[i];
    end else begin : g_fixed
      assign lane_en = 1'b1;
    end
    frz_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_in   (clk_in[i]),
      .rst_n    (rst_n),
      .en_async (lane_en),
      .clk_out  (clk_out[i])
    );
  end

endmodule

// File: tb/test_clk_freeze_ctrl.sv
`timescale 1ns/100ps
module test_clk_freeze_ctrl;

  localparam int NL = 14;
  localparam int NG = 12;

  logic          sclk;
  logic          rst_n;
  logic          sdata;
  logic [NL-1:0] clk_in;
  logic [NL-1:0] clk_out;

  int n_chk  = 0;
  int n_fail = 0;
  int runt_err = 0;
  bit done = 0;

  clk_freeze_ctrl i_clk_freeze_ctrl (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .sdata   (sdata),
    .clk_in  (clk_in),
    .clk_out (clk_out)
  );

  initial begin
    sclk = 1'b0;
    forever #10 sclk = ~sclk;
  end

  // Lane clocks, each with its own period; R8 pulse monitor per lane.
  for (genvar i = 0; i < NL; i++) begin : g_ck
    logic ck;
    assign clk_in[i] = ck;
    initial begin
      ck = 1'b0;
      forever #(5 + i) ck = ~ck;
    end
    initial begin
      forever begin
        logic a, b, r0;
        @(posedge ck);
        r0 = rst_n;
        #1 a = clk_out[i];
        #(5 + i - 2) b = clk_out[i];
        if (r0 && rst_n && a != b) runt_err++;
        @(negedge ck);
        #0.5;
        if (clk_out[i]) runt_err++;
      end
    end
  end

  // Behavioural reference model of the enable word.
  logic [NG-1:0] exp_en;
  bit            collecting;
  bit            fq[$];

  always @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      exp_en     = '1;
      collecting = 0;
      fq.delete();
    end else if (!collecting) begin
      if (!sdata) collecting = 1;
    end else begin
      fq.push_back(sdata);
      if (fq.size() == NG) begin
        for (int k = 0; k < NG; k++) exp_en[k] = fq[k];
        fq.delete();
        collecting = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_lanes(input string tag, input int nsamp, input logic [NL-1:0] want_run);
    int mism [NL];
    for (int i = 0; i < NL; i++) mism[i] = 0;
    #0.5;
    for (int s = 0; s < nsamp; s++) begin
      for (int i = 0; i < NL; i++) begin
        if (want_run[i] ? (clk_out[i] !== clk_in[i]) : (clk_out[i] !== 1'b0)) mism[i]++;
      end
      #2;
    end
    for (int i = 0; i < NL; i++) begin
      check(mism[i] == 0, $sformatf("%s lane%0d run=%0b mismatches", tag, i, want_run[i]), mism[i], 0);
    end
  endtask

  task automatic send_frame(input logic [NG-1:0] d);
    @(negedge sclk) sdata = 1'b0;
    for (int k = 0; k < NG; k++) begin
      @(negedge sclk) sdata = d[k];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge sclk) sdata = 1'b1;
    end
  endtask

  function automatic logic [NL-1:0] model_run();
    return {2'b11, exp_en};
  endfunction

  initial begin
    logic [NL-1:0] prev;
    sdata = 1'b1;
    rst_n = 1'b0;
    #100;
    // R7: reset held, all outputs low
    check_lanes("R7 in reset", 100, '0);
    @(negedge sclk) rst_n = 1'b1;
    idle(15);
    // R7: all lanes run after release
    check_lanes("R7 after release", 100, '1);

    // R1 R4 R5: distinct pattern, bit k -> lane k
    send_frame(12'hA5C);
    idle(12);
    check_lanes("R1 R4 R5 pattern A5C", 100, model_run());

    // R2: long idle keeps state
    prev = model_run();
    idle(40);
    check_lanes("R2 idle high", 100, prev);

    // R3: mid-frame outputs unchanged, then all frozen; R6 fixed lanes run
    prev = model_run();
    fork
      send_frame(12'h000);
      begin
        repeat (3) @(posedge sclk);
        check_lanes("R3 mid-frame", 30, prev);
      end
    join
    idle(12);
    check_lanes("R3 R5 R6 all frozen", 100, 14'h3000);

    // R9: back-to-back frames, the later one wins
    send_frame(12'h3F0);
    send_frame(12'hC0F);
    idle(12);
    check_lanes("R9 back-to-back C0F", 100, {2'b11, 12'hC0F});

    // R5: restore all
    send_frame(12'hFFF);
    idle(12);
    check_lanes("R5 restore", 100, model_run());

    // R7: reset in mid-operation
    send_frame(12'h0F0);
    idle(12);
    check_lanes("R4 R5 pattern 0F0", 100, model_run());
    @(negedge sclk) rst_n = 1'b0;
    #20;
    check_lanes("R7 reset reasserted", 60, '0);
    @(negedge sclk) rst_n = 1'b1;
    idle(15);
    check_lanes("R7 restart", 100, '1);

    // R8: no partial pulse seen by the monitors
    idle(4);
    check(runt_err == 0, "R8 partial pulses", runt_err, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule